// File: doc/BRIEF.md
# Per-Queue Congestion Threshold Controller

This block sits beside a set of cell queues and takes the congestion decisions for them. It does not store cells. For every queue it takes the write and read pointers and works out the occupancy. It checks that occupancy against two thresholds that software programs per queue. One threshold governs the discard of low-priority cells (CLP set) when they arrive. The other governs congestion marking of cells as they leave.

A cell arriving on the enqueue side carries its queue number and its CLP bit. One cycle later the block answers whether that cell is to be thrown away. A cell leaving on the dequeue side hands over its 32-bit header and comes back one cycle later, possibly with its EFCI bit set. A third path covers a single transmit FIFO. That path has its own threshold and global enable, and the caller supplies the FIFO occupancy directly. Two sticky flags per queue record that a threshold was seen exceeded, and a per-queue strobe clears them.

Thresholds are coarse. A threshold covers the count without its three low bits, so any nonzero threshold resolves only to eight cells. A threshold of zero means the queue counts as over its threshold for every cell.

Top module: `cong_thresh_ctrl`

## Requirements
- R1: The occupancy of queue q is (wr_ptr - rd_ptr) modulo 2^16, using 16-bit pointers whose top bit is a wrap bit. A full queue (difference 0x8000) therefore counts as 32768 cells, and equal pointers count as 0.
- R2: A threshold L (13 bits, in units of eight cells) counts as exceeded when L is 0, or when occupancy > 8*L+7. Equivalently, occupancy bits [15:3] are strictly greater than L.
- R3: One cycle after enq_vld, enq_res_vld is 1. enq_drop is 1 exactly when enq_clp was 1, clp_en[q] was 1 and the CLP threshold of queue q was exceeded. When enq_res_vld is 0, enq_drop is 0.
- R4: One cycle after tx_vld, tx_res_vld is 1. tx_drop is 1 exactly when tx_clp and tx_drop_en were 1 and tx_fill exceeded tx_clp_lim under the rule of R2.
- R5: An enqueue on queue q sets clp_flag[q] if the CLP threshold of q is exceeded, and sets fecn_flag[q] if the FECN threshold of q is exceeded. This happens whatever the enables and the cell's CLP bit are, and the flags are visible the next cycle. Dequeues never set flags.
- R6: The flags are sticky. sts_clr[q] clears both flags of queue q the next cycle. A set and a clear of the same flag in the same cycle leaves the flag at 1.
- R7: One cycle after deq_vld, deq_res_vld is 1 and deq_hdr_out equals deq_hdr, with one exception: bit 2 (EFCI) is forced to 1 when deq_hdr bit 3 (PTI MSB) is 0, fecn_en[q] is 1, and the FECN threshold of q is exceeded. Headers with bit 3 set pass unchanged.
- R8: During and after reset, enq_res_vld, enq_drop, deq_res_vld, tx_res_vld, tx_drop and all flags are 0.
- R9: An enqueue and a dequeue in the same cycle on different queues are each decided on their own queue's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ptr_flat | input | 128 | Write pointer of each queue, 16 bits each, queue q at [16q+15:16q] |
| rd_ptr_flat | input | 128 | Read pointer of each queue, same layout |
| clp_lim_flat | input | 104 | CLP threshold per queue, 13 bits each |
| fecn_lim_flat | input | 104 | FECN threshold per queue, 13 bits each |
| clp_en | input | 8 | Per-queue CLP discard enable |
| fecn_en | input | 8 | Per-queue EFCI marking enable |
| enq_vld | input | 1 | Arriving cell present |
| enq_qid | input | 3 | Queue of the arriving cell |
| enq_clp | input | 1 | CLP bit of the arriving cell |
| enq_res_vld | output | 1 | Discard decision valid |
| enq_drop | output | 1 | Discard the arriving cell |
| deq_vld | input | 1 | Leaving cell present |
| deq_qid | input | 3 | Queue of the leaving cell |
| deq_hdr | input | 32 | Header of the leaving cell |
| deq_res_vld | output | 1 | Rewritten header valid |
| deq_hdr_out | output | 32 | Header after optional EFCI marking |
| tx_fill | input | 16 | Transmit FIFO occupancy in cells |
| tx_clp_lim | input | 13 | Transmit FIFO CLP threshold |
| tx_drop_en | input | 1 | Transmit FIFO discard enable |
| tx_vld | input | 1 | Cell arriving at the transmit FIFO |
| tx_clp | input | 1 | CLP bit of that cell |
| tx_res_vld | output | 1 | Transmit discard decision valid |
| tx_drop | output | 1 | Discard the transmit cell |
| sts_clr | input | 8 | Per-queue flag clear strobe |
| clp_flag | output | 8 | Sticky CLP-threshold flags |
| fecn_flag | output | 8 | Sticky FECN-threshold flags |

## Verification
The assertions check on every cycle the local rules. No discard is raised without a CLP-tagged arrival, and no transmit discard without its enable. Flags hold steady unless set or cleared, and a set beats a clear. Every header bit other than EFCI passes through untouched, as does EFCI on non-data cells. Only the bench's scenarios can show that the thresholds land at the right occupancy. They cover the 8*L+7 boundary, the zero-threshold case, the wrapped and full pointer pairs, and simultaneous enqueue and dequeue on separate queues, since each of these depends on the numbers chosen.

// File: rtl/cong_pkg.sv
package cong_pkg;
  // Header bit positions inside the 32-bit cell header (last byte holds PTI/CLP)
  localparam int PTI_MSB_BIT = 3;
  localparam int EFCI_BIT    = 2;

  typedef struct packed {
    logic vld;
    logic drop;
  } drop_res_t;
endpackage

// File: rtl/cong_rst_sync.sv
module cong_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/cong_lim_cmp.sv
module cong_lim_cmp #(
  parameter int CNT_W   = 16,
  parameter int GRAN_SH = 3,
  localparam int LIM_W  = CNT_W - GRAN_SH
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [LIM_W-1:0] lim,
  output logic             exceeded
);
  logic [CNT_W-1:0] edge_cnt;

  // Highest occupancy still inside the threshold: lim*2^GRAN_SH + all-ones
  always_comb begin
    edge_cnt = {lim, {GRAN_SH{1'b1}}};
    exceeded = (lim == '0) || (fill > edge_cnt);
  end
endmodule

// File: rtl/cong_fill_cmp.sv
module cong_fill_cmp #(
  parameter int CNT_W   = 16,
  parameter int GRAN_SH = 3,
  localparam int LIM_W  = CNT_W - GRAN_SH
) (
  input  logic [CNT_W-1:0] wr_ptr,
  input  logic [CNT_W-1:0] rd_ptr,
  input  logic [LIM_W-1:0] clp_lim,
  input  logic [LIM_W-1:0] fecn_lim,
  output logic             clp_exc,
  output logic             fecn_exc
);
  logic [CNT_W-1:0] fill;

  // Modular difference; the pointer MSB is the wrap bit
  always_comb fill = wr_ptr - rd_ptr;

  cong_lim_cmp #(.CNT_W(CNT_W), .GRAN_SH(GRAN_SH)) u_clp (
    .fill(fill), .lim(clp_lim), .exceeded(clp_exc)
  );

  cong_lim_cmp #(.CNT_W(CNT_W), .GRAN_SH(GRAN_SH)) u_fecn (
    .fill(fill), .lim(fecn_lim), .exceeded(fecn_exc)
  );
endmodule

// File: rtl/cong_sticky.sv
module cong_sticky #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_nxt;

  always_comb flag_nxt = set | (flag & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> (flag[i] == $past(flag[i])));
  end
endmodule

// File: rtl/cong_efci_mark.sv
module cong_efci_mark #(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [HDR_W-1:0] in_hdr,
  input  logic             mark_ok,
  output logic             out_vld,
  output logic [HDR_W-1:0] out_hdr
);
  import cong_pkg::*;

  logic             vld_nxt;
  logic             hdr_en;
  logic [HDR_W-1:0] hdr_nxt;

  always_comb begin
    vld_nxt = in_vld;
    hdr_en  = in_vld;
    hdr_nxt = in_hdr;
    if (mark_ok && !in_hdr[PTI_MSB_BIT]) hdr_nxt[EFCI_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_hdr <= '0;
    end else begin
      out_vld <= vld_nxt;
      if (hdr_en) out_hdr <= hdr_nxt;
    end
  end

  // R7
  hdr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ((out_hdr[HDR_W-1:EFCI_BIT+1] == $past(in_hdr[HDR_W-1:EFCI_BIT+1]))
                && (out_hdr[EFCI_BIT-1:0] == $past(in_hdr[EFCI_BIT-1:0]))));
  // R7
  oam_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_hdr[PTI_MSB_BIT]) |=> (out_hdr[EFCI_BIT] == $past(in_hdr[EFCI_BIT])));
endmodule

// File: rtl/cong_thresh_ctrl.sv
module cong_thresh_ctrl #(
  parameter int NUM_Q   = 8,
  parameter int CNT_W   = 16,
  parameter int GRAN_SH = 3,
  parameter int HDR_W   = 32,
  localparam int QID_W  = $clog2(NUM_Q),
  localparam int LIM_W  = CNT_W - GRAN_SH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_Q*CNT_W-1:0] wr_ptr_flat,
  input  logic [NUM_Q*CNT_W-1:0] rd_ptr_flat,
  input  logic [NUM_Q*LIM_W-1:0] clp_lim_flat,
  input  logic [NUM_Q*LIM_W-1:0] fecn_lim_flat,
  input  logic [NUM_Q-1:0]       clp_en,
  input  logic [NUM_Q-1:0]       fecn_en,
  input  logic                   enq_vld,
  input  logic [QID_W-1:0]       enq_qid,
  input  logic                   enq_clp,
  output logic                   enq_res_vld,
  output logic                   enq_drop,
  input  logic                   deq_vld,
  input  logic [QID_W-1:0]       deq_qid,
  input  logic [HDR_W-1:0]       deq_hdr,
  output logic                   deq_res_vld,
  output logic [HDR_W-1:0]       deq_hdr_out,
  input  logic [CNT_W-1:0]       tx_fill,
  input  logic [LIM_W-1:0]       tx_clp_lim,
  input  logic                   tx_drop_en,
  input  logic                   tx_vld,
  input  logic                   tx_clp,
  output logic                   tx_res_vld,
  output logic                   tx_drop,
  input  logic [NUM_Q-1:0]       sts_clr,
  output logic [NUM_Q-1:0]       clp_flag,
  output logic [NUM_Q-1:0]       fecn_flag
);
  import cong_pkg::*;

  logic rst_n_s;
  cong_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  // Per-queue occupancy and threshold compares
  logic [NUM_Q-1:0] clp_exc;
  logic [NUM_Q-1:0] fecn_exc;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    cong_fill_cmp #(.CNT_W(CNT_W), .GRAN_SH(GRAN_SH)) u_cmp (
      .wr_ptr  (wr_ptr_flat[q*CNT_W +: CNT_W]),
      .rd_ptr  (rd_ptr_flat[q*CNT_W +: CNT_W]),
      .clp_lim (clp_lim_flat[q*LIM_W +: LIM_W]),
      .fecn_lim(fecn_lim_flat[q*LIM_W +: LIM_W]),
      .clp_exc (clp_exc[q]),
      .fecn_exc(fecn_exc[q])
    );
  end

  // Transmit FIFO compare
  logic tx_exc;
  cong_lim_cmp #(.CNT_W(CNT_W), .GRAN_SH(GRAN_SH)) u_tx_cmp (
    .fill(tx_fill), .lim(tx_clp_lim), .exceeded(tx_exc)
  );

  // Ingress discard decisions
  drop_res_t enq_nxt, enq_q, tx_nxt, tx_q;
  logic [NUM_Q-1:0] clp_set, fecn_set;

  always_comb begin
    enq_nxt.vld  = enq_vld;
    enq_nxt.drop = enq_vld && enq_clp && clp_en[enq_qid] && clp_exc[enq_qid];
    tx_nxt.vld   = tx_vld;
    tx_nxt.drop  = tx_vld && tx_clp && tx_drop_en && tx_exc;
    clp_set      = '0;
    fecn_set     = '0;
    if (enq_vld) begin
      clp_set[enq_qid]  = clp_exc[enq_qid];
      fecn_set[enq_qid] = fecn_exc[enq_qid];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      enq_q <= '0;
      tx_q  <= '0;
    end else begin
      enq_q <= enq_nxt;
      tx_q  <= tx_nxt;
    end
  end

  always_comb begin
    enq_res_vld = enq_q.vld;
    enq_drop    = enq_q.drop;
    tx_res_vld  = tx_q.vld;
    tx_drop     = tx_q.drop;
  end

  // Sticky status
  cong_sticky #(.N(NUM_Q)) u_clp_sts (
    .clk(clk), .rst_n(rst_n_s), .set(clp_set), .clr(sts_clr), .flag(clp_flag)
  );
  cong_sticky #(.N(NUM_Q)) u_fecn_sts (
    .clk(clk), .rst_n(rst_n_s), .set(fecn_set), .clr(sts_clr), .flag(fecn_flag)
  );

  // Egress marking
  logic deq_mark_ok;
  always_comb deq_mark_ok = fecn_en[deq_qid] && fecn_exc[deq_qid];

  cong_efci_mark #(.HDR_W(HDR_W)) u_mark (
    .clk(clk), .rst_n(rst_n_s), .in_vld(deq_vld), .in_hdr(deq_hdr),
    .mark_ok(deq_mark_ok), .out_vld(deq_res_vld), .out_hdr(deq_hdr_out)
  );

  // R3
  drop_clp_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    enq_vld |=> (enq_drop |-> $past(enq_clp)));
  // R3
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enq_res_vld |-> !enq_drop);
  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_vld |=> (tx_drop |-> $past(tx_drop_en && tx_clp)));
  // R4
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tx_res_vld |-> !tx_drop);
endmodule

// File: tb/sim_cong_thresh_ctrl.sv
module sim_cong_thresh_ctrl;
  localparam int NQ = 8;
  localparam int CW = 16;
  localparam int LW = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n;
  logic [NQ*CW-1:0] wr_flat, rd_flat;
  logic [NQ*LW-1:0] clim_flat, flim_flat;
  logic [NQ-1:0] clp_en, fecn_en, sts_clr, clp_flag, fecn_flag;
  logic enq_vld, enq_clp, enq_res_vld, enq_drop;
  logic [2:0] enq_qid, deq_qid;
  logic deq_vld, deq_res_vld;
  logic [31:0] deq_hdr, deq_hdr_out;
  logic [CW-1:0] tx_fill;
  logic [LW-1:0] tx_clp_lim;
  logic tx_drop_en, tx_vld, tx_clp, tx_res_vld, tx_drop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  cong_thresh_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_ptr_flat(wr_flat), .rd_ptr_flat(rd_flat),
    .clp_lim_flat(clim_flat), .fecn_lim_flat(flim_flat), .clp_en(clp_en),
    .fecn_en(fecn_en), .enq_vld(enq_vld), .enq_qid(enq_qid), .enq_clp(enq_clp),
    .enq_res_vld(enq_res_vld), .enq_drop(enq_drop), .deq_vld(deq_vld),
    .deq_qid(deq_qid), .deq_hdr(deq_hdr), .deq_res_vld(deq_res_vld),
    .deq_hdr_out(deq_hdr_out), .tx_fill(tx_fill), .tx_clp_lim(tx_clp_lim),
    .tx_drop_en(tx_drop_en), .tx_vld(tx_vld), .tx_clp(tx_clp),
    .tx_res_vld(tx_res_vld), .tx_drop(tx_drop), .sts_clr(sts_clr),
    .clp_flag(clp_flag), .fecn_flag(fecn_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs change and outputs are sampled 1 ns after a rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setq(input int q, input logic [15:0] wr, input logic [15:0] rd,
                      input logic [12:0] cl, input logic [12:0] fl);
    wr_flat[q*CW +: CW] = wr;
    rd_flat[q*CW +: CW] = rd;
    clim_flat[q*LW +: LW] = cl;
    flim_flat[q*LW +: LW] = fl;
  endtask

  task automatic enq(input int q, input logic clp);
    enq_vld = 1; enq_qid = 3'(q); enq_clp = clp;
    tick();
    enq_vld = 0; enq_clp = 0;
  endtask

  task automatic clear_all();
    sts_clr = '1; tick(); sts_clr = '0;
  endtask

  task automatic t_reset();
    chk("R8 enq_res_vld", 32'(enq_res_vld), 0);
    chk("R8 enq_drop", 32'(enq_drop), 0);
    chk("R8 deq_res_vld", 32'(deq_res_vld), 0);
    chk("R8 tx_res_vld/tx_drop", {30'd0, tx_res_vld, tx_drop}, 0);
    chk("R8 flags", {16'd0, clp_flag, fecn_flag}, 0);
  endtask

  task automatic t_clp_boundary();
    clp_en[2] = 1;
    setq(2, 16'd139, 16'd100, 13'd4, 13'h1FFF);  // fill 39 = 8*4+7
    enq(2, 1);
    chk("R3 valid", 32'(enq_res_vld), 1);
    chk("R2 fill 39 lim 4 no drop", 32'(enq_drop), 0);
    setq(2, 16'd140, 16'd100, 13'd4, 13'h1FFF);  // fill 40
    enq(2, 1);
    chk("R2 fill 40 lim 4 drop", 32'(enq_drop), 1);
    enq(2, 0);
    chk("R3 clp=0 kept", 32'(enq_drop), 0);
    clear_all();
    clp_en[2] = 0;
    enq(2, 1);
    chk("R3 disabled no drop", 32'(enq_drop), 0);
    chk("R5 flag set while disabled", 32'(clp_flag[2]), 1);
    tick();
    chk("R3 idle no drop", {30'd0, enq_res_vld, enq_drop}, 0);
  endtask

  task automatic t_wrap();
    clp_en[3] = 1;
    setq(3, 16'h0005, 16'hFFF0, 13'd1, 13'h1FFF);  // fill 21
    enq(3, 1);
    chk("R1 wrapped fill 21 > lim1", 32'(enq_drop), 1);
    setq(3, 16'h0005, 16'hFFF0, 13'd2, 13'h1FFF);
    enq(3, 1);
    chk("R1 wrapped fill 21 <= lim2", 32'(enq_drop), 0);
    setq(3, 16'h8000, 16'h0000, 13'h0FFF, 13'h1FFF);  // full
    enq(3, 1);
    chk("R1 full queue counted", 32'(enq_drop), 1);
    setq(3, 16'h1234, 16'h1234, 13'd1, 13'h1FFF);  // empty
    enq(3, 1);
    chk("R1 empty queue", 32'(enq_drop), 0);
    clp_en[3] = 0;
  endtask

  task automatic t_zero_lim();
    clear_all();
    setq(4, 16'd0, 16'd0, 13'h1FFF, 13'd0);
    enq(4, 0);
    chk("R5 zero lim first cell fecn flag", 32'(fecn_flag), 32'h10);
    chk("R5 clp flag untouched", 32'(clp_flag), 0);
    clp_en[4] = 1;
    setq(4, 16'd0, 16'd0, 13'd0, 13'h1FFF);
    enq(4, 1);
    chk("R2 zero lim drops", 32'(enq_drop), 1);
    clp_en[4] = 0;
  endtask

  task automatic t_sticky();
    clear_all();
    setq(1, 16'd200, 16'd0, 13'd2, 13'd2);
    enq(1, 0);
    setq(1, 16'd0, 16'd0, 13'h1FFF, 13'h1FFF);
    tick(); tick();
    chk("R6 sticky after queue drains", {16'd0, clp_flag, fecn_flag}, 32'h0202);
    sts_clr = 8'h02; tick(); sts_clr = '0;
    chk("R6 clear", {16'd0, clp_flag, fecn_flag}, 0);
    setq(1, 16'd200, 16'd0, 13'd2, 13'h1FFF);
    sts_clr = 8'h02; enq_vld = 1; enq_qid = 3'd1; tick();
    sts_clr = '0; enq_vld = 0;
    chk("R6 set wins over clear", {16'd0, clp_flag, fecn_flag}, 32'h0200);
  endtask

  task automatic deq(input int q, input logic [31:0] h);
    deq_vld = 1; deq_qid = 3'(q); deq_hdr = h;
    tick();
    deq_vld = 0;
  endtask

  task automatic t_mark();
    clear_all();
    fecn_en[5] = 1;
    setq(5, 16'd100, 16'd0, 13'h1FFF, 13'd2);
    deq(5, 32'h12345670);
    chk("R7 valid", 32'(deq_res_vld), 1);
    chk("R7 data cell marked", deq_hdr_out, 32'h12345674);
    deq(5, 32'hABCDEF0A);
    chk("R7 non-data unchanged", deq_hdr_out, 32'hABCDEF0A);
    setq(5, 16'd23, 16'd0, 13'h1FFF, 13'd2);
    deq(5, 32'h0F0F0F01);
    chk("R7 below lim unchanged", deq_hdr_out, 32'h0F0F0F01);
    setq(5, 16'd100, 16'd0, 13'h1FFF, 13'd2);
    fecn_en[5] = 0;
    deq(5, 32'h0F0F0F01);
    chk("R7 disabled unchanged", deq_hdr_out, 32'h0F0F0F01);
    chk("R5 dequeue sets no flag", 32'(fecn_flag), 0);
  endtask

  task automatic t_tx();
    tx_fill = 16'h0100; tx_clp_lim = 13'h010; tx_drop_en = 1;
    tx_vld = 1; tx_clp = 1; tick(); tx_vld = 0;
    chk("R4 tx drop", {30'd0, tx_res_vld, tx_drop}, 3);
    tx_drop_en = 0; tx_vld = 1; tick(); tx_vld = 0;
    chk("R4 tx disabled", {30'd0, tx_res_vld, tx_drop}, 2);
    tx_drop_en = 1; tx_clp = 0; tx_vld = 1; tick(); tx_vld = 0;
    chk("R4 tx clp=0", 32'(tx_drop), 0);
    tx_clp = 1; tx_fill = 16'h0087; tx_vld = 1; tick(); tx_vld = 0;
    chk("R4 tx at boundary kept", 32'(tx_drop), 0);
  endtask

  task automatic t_concurrent();
    clear_all();
    clp_en[6] = 1; fecn_en[7] = 1;
    setq(6, 16'd16, 16'd0, 13'd1, 13'h1FFF);
    setq(7, 16'd0, 16'd0, 13'h1FFF, 13'd0);
    enq_vld = 1; enq_qid = 3'd6; enq_clp = 1;
    deq_vld = 1; deq_qid = 3'd7; deq_hdr = 32'h0;
    tick();
    enq_vld = 0; deq_vld = 0;
    chk("R9 enq drop on q6", 32'(enq_drop), 1);
    chk("R9 deq mark on q7", deq_hdr_out, 32'h4);
    chk("R9 flags only q6 clp", {16'd0, clp_flag, fecn_flag}, 32'h4000);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    wr_flat = '0; rd_flat = '0; clim_flat = '1; flim_flat = '1;
    clp_en = '0; fecn_en = '0; sts_clr = '0;
    enq_vld = 0; enq_qid = '0; enq_clp = 0;
    deq_vld = 0; deq_qid = '0; deq_hdr = '0;
    tx_fill = '0; tx_clp_lim = '1; tx_drop_en = 0; tx_vld = 0; tx_clp = 0;
    for (int i = 0; i < NQ; i++) setq(i, 16'd0, 16'd0, 13'h1FFF, 13'h1FFF);
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_clp_boundary();
    t_wrap();
    t_zero_lim();
    t_sticky();
    t_mark();
    t_tx();
    t_concurrent();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule